// File: doc/BRIEF.md
# Asynchronous Serial Controller Host Register Front End

This block sits between a processor bus and the transmit and receive engines of an asynchronous serial controller. The processor reaches it through a chip select, one address line, read and write strobes and an 8-bit data bus. With the address line low, the processor is talking to the data port. With it high, the processor is talking to the control/status port. Writes to the control port go through a two-state write-order sequencer. In state `SEQ_MODE`, the next control write is taken as the mode byte. In state `SEQ_CMD`, control writes are taken as command bytes.

The sequencer has three transitions. `SEQ_MODE -> SEQ_CMD` happens when a mode byte is stored. `SEQ_CMD -> SEQ_MODE` happens when a command with the mode-return bit set is stored, or when the soft-reset code arrives. The soft-reset code `0x40` is also accepted in `SEQ_MODE`, where it leaves the sequencer in `SEQ_MODE`. Hardware reset enters `SEQ_MODE`.

The block keeps the status flags and drives the active-low modem-control pins. It hands each written transmit byte to the transmitter with a one-cycle load pulse. It latches received characters and gathers error pulses from the engines. The mode and command bytes are exported to the serial engines. Bit timing itself lives in those engines.

Top module: `usart_host_if`

## Requirements
- R1: A read with `cs`=1, `rd`=1, `a0`=0 shows the last received character on `dout` in the same cycle. With `a0`=1, `dout` shows the status byte.
- R2: After hardware reset, the sequencer is in `SEQ_MODE` and `mode_out`=`cmd_out`=0. `dtr_n`=`rts_n`=1 and `brk`=0. With `dsr_n`=1 the status byte reads 0x05.
- R3: In `SEQ_MODE`, a control write of any value other than 0x40 loads `mode_out` on the next clock and moves the sequencer to `SEQ_CMD`. In `SEQ_CMD`, control writes load `cmd_out` and leave `mode_out` unchanged.
- R4: A control write of 0x40 in either state clears the mode byte, the command byte, the received character and all flags. The status byte then reads 0x05 (with `dsr_n`=1), and the next control write is taken as a mode byte.
- R5: A command byte with bit 6 set is stored, and the sequencer returns to `SEQ_MODE`.
- R6: Status bit positions are as follows. Bit 7 = NOT `dsr_n`. Bit 6 always reads 0. Bit 5 = framing error, bit 4 = overrun error, bit 3 = parity error. Bit 2 = transmitter empty, bit 1 = receive ready, bit 0 = transmit ready.
- R7: A command byte with bit 4 set clears the parity, overrun and framing flags. `pe_in`/`fe_in` pulses set their flags.
- R8: Command bit 1 drives `dtr_n` low and bit 5 drives `rts_n` low. Bit 3 drives `brk` high. Bit 0 enables the transmitter (`tx_en`) and bit 2 enables the receiver (`rx_en`).
- R9: An `rx_valid` pulse latches `rx_char` and sets receive ready. If receive ready was already set, the overrun flag is set as well. A data-port read clears receive ready.
- R10: A data-port write gives `tx_load`=1 for exactly the following cycle, with `tx_data` holding the byte. It clears transmit ready and transmitter empty. `tx_take` sets transmit ready again and `tx_done` sets transmitter empty again.
- R11: In `SEQ_CMD` with command bit 0 clear, transmit ready reads 0 whatever the buffer state. In `SEQ_MODE` it shows the buffer state alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| a0 | input | 1 | Port select: 0 data, 1 control/status |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| mode_out | output | 8 | Stored mode byte |
| cmd_out | output | 8 | Stored command byte |
| tx_load | output | 1 | One-cycle transmit load pulse |
| tx_data | output | 8 | Byte for the transmitter |
| tx_take | input | 1 | Transmitter accepted the byte |
| tx_done | input | 1 | Transmitter shifted out its last bit |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| brk | output | 1 | Force serial line low |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| pe_in | input | 1 | Parity error pulse |
| fe_in | input | 1 | Framing error pulse |
| dsr_n | input | 1 | Active-low data-set-ready input |
| dtr_n | output | 1 | Active-low data-terminal-ready output |
| rts_n | output | 1 | Active-low request-to-send output |

## Verification
Suppose the sequencer state is wrong. The next control write then lands in the wrong register, so `mode_out` or `cmd_out` goes wrong one clock later. Transmit ready at status bit 0 also flips, because its gating depends on the state. A stuck or lost flag shows up on the very next status read. A missed overrun or error clear shows only when a later status read is compared with the expected byte. For that reason, the stimulus reads status after every operation.

// File: rtl/usart_host_pkg.sv
package usart_host_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        SEQ_MODE = 1'b0,
        SEQ_CMD  = 1'b1
    } seq_state_t;

    // command byte bit positions
    localparam int CB_TXE  = 0;
    localparam int CB_DTR  = 1;
    localparam int CB_RXE  = 2;
    localparam int CB_SBRK = 3;
    localparam int CB_ERR  = 4;
    localparam int CB_RTS  = 5;
    localparam int CB_IR   = 6;

    localparam logic [BYTE_W-1:0] SOFT_RST_CODE = 8'h40;
endpackage

// File: rtl/usart_seq.sv
module usart_seq
    import usart_host_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] cmd_q,
    output logic          soft_rst,
    output logic          err_clr,
    output logic          in_cmd
);
    seq_state_t state_q, state_d;
    logic       rst_code;

    assign rst_code = ctl_wr && (wdata == DW'(SOFT_RST_CODE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_MODE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_MODE: if (ctl_wr && !rst_code) state_d = SEQ_CMD;
            SEQ_CMD:  if (rst_code || (ctl_wr && wdata[CB_IR])) state_d = SEQ_MODE;
            default:  state_d = SEQ_MODE;
        endcase
    end

    // stored bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            cmd_q  <= '0;
        end else if (rst_code) begin
            mode_q <= '0;
            cmd_q  <= '0;
        end else if (ctl_wr) begin
            unique case (state_q)
                SEQ_MODE: mode_q <= wdata;
                SEQ_CMD:  cmd_q  <= wdata;
                default:  mode_q <= wdata;
            endcase
        end
    end

    assign soft_rst = rst_code;
    assign err_clr  = ctl_wr && !rst_code && (state_q == SEQ_CMD) && wdata[CB_ERR];
    assign in_cmd   = (state_q == SEQ_CMD);
endmodule

// File: rtl/usart_stat.sv
module usart_stat
    import usart_host_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          err_clr,
    input  logic          in_cmd,
    input  logic          txe,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          rx_valid,
    input  logic          tx_take,
    input  logic          tx_done,
    input  logic          pe_in,
    input  logic          fe_in,
    input  logic          dsr_n,
    output logic [DW-1:0] status
);
    logic rx_rdy, pe_f, oe_f, fe_f, tx_full, tx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_rdy   <= 1'b0;
            pe_f     <= 1'b0;
            oe_f     <= 1'b0;
            fe_f     <= 1'b0;
            tx_full  <= 1'b0;
            tx_empty <= 1'b1;
        end else if (soft_rst) begin
            rx_rdy   <= 1'b0;
            pe_f     <= 1'b0;
            oe_f     <= 1'b0;
            fe_f     <= 1'b0;
            tx_full  <= 1'b0;
            tx_empty <= 1'b1;
        end else begin
            if (rx_valid)     rx_rdy <= 1'b1;
            else if (data_rd) rx_rdy <= 1'b0;
            oe_f <= (oe_f && !err_clr) || (rx_valid && rx_rdy);
            pe_f <= (pe_f && !err_clr) || pe_in;
            fe_f <= (fe_f && !err_clr) || fe_in;
            if (data_wr)      tx_full <= 1'b1;
            else if (tx_take) tx_full <= 1'b0;
            if (data_wr)      tx_empty <= 1'b0;
            else if (tx_done) tx_empty <= 1'b1;
        end
    end

    always_comb begin
        status    = '0;
        status[7] = !dsr_n;
        status[6] = 1'b0;
        status[5] = fe_f;
        status[4] = oe_f;
        status[3] = pe_f;
        status[2] = tx_empty;
        status[1] = rx_rdy;
        status[0] = !tx_full && (!in_cmd || txe);
    end
endmodule

// File: rtl/usart_host_if.sv
module usart_host_if
    import usart_host_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          a0,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] mode_out,
    output logic [DW-1:0] cmd_out,
    output logic          tx_load,
    output logic [DW-1:0] tx_data,
    input  logic          tx_take,
    input  logic          tx_done,
    output logic          tx_en,
    output logic          rx_en,
    output logic          brk,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_char,
    input  logic          pe_in,
    input  logic          fe_in,
    input  logic          dsr_n,
    output logic          dtr_n,
    output logic          rts_n
);
    logic          ctl_wr, data_wr, data_rd;
    logic          soft_rst, err_clr, seq_in_cmd;
    logic [DW-1:0] status_b, rx_buf;

    assign ctl_wr  = cs && wr && a0;
    assign data_wr = cs && wr && !a0;
    assign data_rd = cs && rd && !a0;

    usart_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(din),
        .mode_q(mode_out), .cmd_q(cmd_out),
        .soft_rst(soft_rst), .err_clr(err_clr), .in_cmd(seq_in_cmd)
    );

    usart_stat #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .err_clr(err_clr),
        .in_cmd(seq_in_cmd), .txe(cmd_out[CB_TXE]),
        .data_wr(data_wr), .data_rd(data_rd), .rx_valid(rx_valid),
        .tx_take(tx_take), .tx_done(tx_done), .pe_in(pe_in), .fe_in(fe_in),
        .dsr_n(dsr_n), .status(status_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            tx_data <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= data_wr;
            if (data_wr) tx_data <= din;
            if (soft_rst)      rx_buf <= '0;
            else if (rx_valid) rx_buf <= rx_char;
        end
    end

    assign dout  = a0 ? status_b : rx_buf;
    assign tx_en = cmd_out[CB_TXE];
    assign rx_en = cmd_out[CB_RXE];
    assign brk   = cmd_out[CB_SBRK];
    assign dtr_n = !cmd_out[CB_DTR];
    assign rts_n = !cmd_out[CB_RTS];
endmodule

// File: rtl/usart_host_if_chk.sv
module usart_host_if_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          a0,
    input logic          rd,
    input logic          wr,
    input logic [DW-1:0] din,
    input logic [DW-1:0] mode_out,
    input logic          tx_load,
    input logic [DW-1:0] tx_data,
    input logic          tx_en,
    input logic          rx_valid,
    input logic          pe_in,
    input logic          fe_in,
    input logic          dtr_n,
    input logic          rts_n,
    input logic          seq_in_cmd,
    input logic [DW-1:0] status_b
);
    a_r3_mode_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && a0 && !seq_in_cmd && din != 8'h40)
        |=> (mode_out == $past(din)) && seq_in_cmd);

    a_r4_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && a0 && din == 8'h40)
        |=> (status_b[6:0] == 7'h05) && (mode_out == '0) && !seq_in_cmd && dtr_n && rts_n);

    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && a0 && seq_in_cmd && din[4] && din != 8'h40 && !pe_in && !fe_in && !rx_valid)
        |=> (status_b[5:3] == 3'b000));

    a_r8_modem_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && a0 && seq_in_cmd && din != 8'h40)
        |=> (dtr_n == !$past(din[1])) && (rts_n == !$past(din[5])));

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !wr && !a0 && !rx_valid) |=> !status_b[1]);

    a_r10_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !a0) |=> tx_load && (tx_data == $past(din)) && !status_b[0]);

    a_r11_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_in_cmd && !tx_en) |-> !status_b[0]);
endmodule

bind usart_host_if usart_host_if_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .rd(rd), .wr(wr), .din(din),
    .mode_out(mode_out), .tx_load(tx_load), .tx_data(tx_data), .tx_en(tx_en),
    .rx_valid(rx_valid), .pe_in(pe_in), .fe_in(fe_in), .dtr_n(dtr_n),
    .rts_n(rts_n), .seq_in_cmd(seq_in_cmd), .status_b(status_b)
);

// File: tb/sim_usart_host_if.sv
`timescale 1ns/1ps
module sim_usart_host_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 0, a0 = 0, rd = 0, wr = 0;
    logic [7:0] din = 0, rx_char = 0;
    logic       tx_take = 0, tx_done = 0, rx_valid = 0, pe_in = 0, fe_in = 0;
    logic       dsr_n = 1'b1;
    logic [7:0] dout, mode_out, cmd_out, tx_data;
    logic       tx_load, tx_en, rx_en, brk, dtr_n, rts_n;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [7:0] m_mode = 0, m_cmd = 0, m_rx = 0;
    bit m_incmd = 0, m_rxrdy = 0, m_pe = 0, m_oe = 0, m_fe = 0, m_full = 0, m_empty = 1;

    always #2 clk = ~clk;

    usart_host_if u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .rd(rd), .wr(wr), .din(din),
        .dout(dout), .mode_out(mode_out), .cmd_out(cmd_out), .tx_load(tx_load),
        .tx_data(tx_data), .tx_take(tx_take), .tx_done(tx_done), .tx_en(tx_en),
        .rx_en(rx_en), .brk(brk), .rx_valid(rx_valid), .rx_char(rx_char),
        .pe_in(pe_in), .fe_in(fe_in), .dsr_n(dsr_n), .dtr_n(dtr_n), .rts_n(rts_n)
    );

    function automatic logic [7:0] exp_status();
        return {~dsr_n, 1'b0, m_fe, m_oe, m_pe, m_empty, m_rxrdy,
                ~m_full & (~m_incmd | m_cmd[0])};
    endfunction

    function automatic logic [7:0] exp_pins();
        return {3'b000, ~m_cmd[1], ~m_cmd[5], m_cmd[3], m_cmd[0], m_cmd[2]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        cs = 0; rd = 0; wr = 0; rx_valid = 0; tx_take = 0; tx_done = 0; pe_in = 0; fe_in = 0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic ctl_wr(input logic [7:0] d);
        cs = 1; a0 = 1; wr = 1; din = d; tick();
        if (d == 8'h40) begin
            m_mode = 0; m_cmd = 0; m_incmd = 0; m_rx = 0; m_rxrdy = 0;
            m_pe = 0; m_oe = 0; m_fe = 0; m_full = 0; m_empty = 1;
        end else if (!m_incmd) begin
            m_mode = d; m_incmd = 1;
        end else begin
            m_cmd = d;
            if (d[4]) begin m_pe = 0; m_oe = 0; m_fe = 0; end
            if (d[6]) m_incmd = 0;
        end
    endtask

    task automatic dat_wr(input logic [7:0] d);
        cs = 1; a0 = 0; wr = 1; din = d; tick();
        chk(tx_load == 1'b1 && tx_data == d, "R10 load", {tx_load, tx_data[6:0]}, {1'b1, d[6:0]});
        m_full = 1; m_empty = 0;
    endtask

    task automatic dat_rd();
        cs = 1; a0 = 0; rd = 1; #1;
        chk(dout == m_rx, "R1 data read", dout, m_rx);
        tick();
        m_rxrdy = 0;
    endtask

    task automatic rx_in(input logic [7:0] c);
        rx_valid = 1; rx_char = c; tick();
        if (m_rxrdy) m_oe = 1;
        m_rx = c; m_rxrdy = 1;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: tx_take = 1;
            1: tx_done = 1;
            2: pe_in = 1;
            default: fe_in = 1;
        endcase
        tick();
        case (which)
            0: m_full = 0;
            1: m_empty = 1;
            2: m_pe = 1;
            default: m_fe = 1;
        endcase
    endtask

    task automatic st_chk(input string tag);
        cs = 1; a0 = 1; rd = 1; #1;
        chk(dout == exp_status(), tag, dout, exp_status());
        tick();
    endtask

    task automatic out_chk(input string tag);
        chk(mode_out == m_mode, tag, mode_out, m_mode);
        chk(cmd_out == m_cmd, tag, cmd_out, m_cmd);
        chk({3'b000, dtr_n, rts_n, brk, tx_en, rx_en} == exp_pins(), tag,
            {3'b000, dtr_n, rts_n, brk, tx_en, rx_en}, exp_pins());
        chk(tx_load == 1'b0, "R10 pulse width", {7'b0, tx_load}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        st_chk("R2 reset status");
        out_chk("R2 reset outputs");

        // R3 mode then command; R8 pins; R11 gating
        ctl_wr(8'h4E);
        out_chk("R3 mode stored");
        ctl_wr(8'h27);
        out_chk("R8 dtr rts enables");
        st_chk("R11 txrdy with TxE set");
        ctl_wr(8'h2E);
        out_chk("R3 command only");
        st_chk("R11 txrdy gated");

        // R9 receive and overrun, R1 read
        rx_in(8'hA5);
        st_chk("R9 rxrdy set");
        rx_in(8'h3C);
        st_chk("R9 overrun");
        dat_rd();
        st_chk("R9 rxrdy cleared");

        // R7 error clear
        pulse(2); pulse(3);
        st_chk("R7 errors set");
        ctl_wr(8'h17);
        st_chk("R7 errors cleared");

        // R6 dsr
        dsr_n = 1'b0;
        st_chk("R6 dsr bit");
        dsr_n = 1'b1;

        // R10 transmit path
        dat_wr(8'h5A);
        st_chk("R10 buffer full");
        pulse(0);
        st_chk("R10 taken");
        pulse(1);
        st_chk("R10 drained");

        // R5 IR return
        ctl_wr(8'h41);
        ctl_wr(8'h8E);
        out_chk("R5 mode after IR");

        // R4 soft reset
        rx_in(8'h77);
        ctl_wr(8'h40);
        st_chk("R4 soft reset status");
        out_chk("R4 soft reset outputs");
        ctl_wr(8'h11);
        out_chk("R4 next write is mode");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] v;
            op = int'($urandom_range(0, 8));
            v  = 8'($urandom);
            case (op)
                0: ctl_wr(($urandom_range(0, 7) == 0) ? 8'h40 : v);
                1: ctl_wr(v);
                2: dat_wr(v);
                3: dat_rd();
                4: rx_in(v);
                5: pulse(0);
                6: pulse(1);
                7: pulse(int'($urandom_range(2, 3)));
                default: dsr_n = v[0];
            endcase
            st_chk("R6 random status");
            out_chk("R8 random outputs");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule